// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on the host side of a parallel NOR flash model. It handles erase commands. It watches every bus write cycle, which is an address plus a data byte. It recognises the six-write unlock sequences that request a whole-array erase or a single-block erase, and tracks an unlock-bypass mode in which a whole-array erase needs only two writes. When a sequence completes, it fires a one-cycle start pulse to an external erase engine, together with the erase kind and the target address.

After the engine starts, the sequencer switches bus reads from array data to a status word and ignores all writes. When the engine reports that it has finished, the sequencer returns to array reads on its own. If the engine reports a failure, status reads stay in place until the host writes the read/reset code. A synchronous hardware reset abandons whatever is in flight and returns to array reads with bypass off.

Top module: `nor_erase_seq`

## Requirements
- R1: Six writes start a whole-array erase: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Addresses are compared on bits [11:0] and codes on data bits [7:0]. In the cycle after the final write, `eng_start` is high for exactly one cycle and `eng_chip` is 1.
- R2: The same five leading writes followed by 30h at any address start a block erase. `eng_start` pulses, `eng_chip` is 0 and `eng_addr` equals the address of that final write.
- R3: The writes AAh@555h, 55h@2AAh, 20h@555h turn `bypass_on` on. While bypass is on, 80h then 10h at any addresses start a whole-array erase. 90h then 00h at any addresses turn bypass off.
- R4: While an erase runs, a read returns the status word instead of array data. In this word bit 7 (busy) is 1 and all other bits are 0. `bus_rdata` is registered and valid from the cycle after `bus_rd_en` is sampled.
- R5: While an erase runs, every write is ignored, including F0h and complete erase sequences. No new start is issued and status reads continue.
- R6: When `eng_done` is sampled with `eng_err` low, the block returns to read mode. `stat_mode` drops and reads return array data again.
- R7: When `eng_done` is sampled with `eng_err` high, the block enters an error state. In this state reads return a status word with bit 5 (error) set and bit 7 clear. The state survives any write except F0h (at any address), which returns the block to read mode.
- R8: A write that does not match the next expected step abandons the sequence without a start. The next correct full sequence still works.
- R9: A high `rst` aborts a running erase. It forces read mode, no status, and bypass off.
- R10: In read mode, a read returns `arr_rdata` as sampled with `bus_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr_en | input | 1 | Bus write cycle strobe |
| bus_addr | input | AW | Bus address for writes |
| bus_wdata | input | DW | Bus write data |
| bus_rd_en | input | 1 | Bus read cycle strobe |
| arr_rdata | input | DW | Array data offered for the current read |
| bus_rdata | output | DW | Registered read data: array data or status word |
| stat_mode | output | 1 | Reads currently return status |
| bypass_on | output | 1 | Unlock-bypass mode active |
| eng_start | output | 1 | One-cycle erase start pulse |
| eng_chip | output | 1 | Erase kind: 1 whole array, 0 single block |
| eng_addr | output | AW | Address of the write that started the erase |
| eng_done | input | 1 | Erase engine finished (one-cycle pulse) |
| eng_err | input | 1 | Engine failure flag, valid with eng_done |

## Verification
The six-write whole-array and block sequences are driven with random block addresses. These runs show that the final code alone picks the erase kind, and that the address is taken only from the last write. Broken sequences cut off at different steps, by a wrong code or a wrong address, show that a partial match never starts the engine and never leaves stale progress behind. Writes during a running erase and during the error state, including F0h and full command sequences, show which codes each state honours. Random array reads in read mode, compared against status reads in the busy and error states, show where the read path switches over.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  localparam int CODE_W     = 8;
  localparam int CMD_AW     = 12;
  localparam int STAT_BUSY  = 7;
  localparam int STAT_ERR   = 5;

  localparam logic [CODE_W-1:0] C_UNLK_A   = 8'hAA;
  localparam logic [CODE_W-1:0] C_UNLK_B   = 8'h55;
  localparam logic [CODE_W-1:0] C_SETUP    = 8'h80;
  localparam logic [CODE_W-1:0] C_WHOLE    = 8'h10;
  localparam logic [CODE_W-1:0] C_BLOCK    = 8'h30;
  localparam logic [CODE_W-1:0] C_BYP_ON   = 8'h20;
  localparam logic [CODE_W-1:0] C_BYP_OFF1 = 8'h90;
  localparam logic [CODE_W-1:0] C_BYP_OFF2 = 8'h00;
  localparam logic [CODE_W-1:0] C_RESET    = 8'hF0;

  localparam logic [CMD_AW-1:0] A_UNLK_A = 12'h555;
  localparam logic [CMD_AW-1:0] A_UNLK_B = 12'h2AA;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_BUSY = 2'd1,
    MODE_ERR  = 2'd2
  } op_mode_e;

  typedef enum logic [3:0] {
    D_IDLE   = 4'd0,
    D_UA1    = 4'd1,
    D_UB1    = 4'd2,
    D_ARMED  = 4'd3,
    D_UA2    = 4'd4,
    D_UB2    = 4'd5,
    D_BP     = 4'd8,
    D_BP_SET = 4'd9,
    D_BP_OFF = 4'd10
  } dec_state_e;

endpackage

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_erase_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hit_whole,
  output logic          hit_block,
  output logic          bypass
);

  dec_state_e state_q, state_d;
  logic [CODE_W-1:0] code;
  logic [CMD_AW-1:0] cadr;
  logic at_a, at_b, take;

  assign code = wr_data[CODE_W-1:0];
  assign cadr = wr_addr[CMD_AW-1:0];
  assign at_a = (cadr == A_UNLK_A);
  assign at_b = (cadr == A_UNLK_B);
  assign take = accept && wr_en;
  assign bypass = state_q[3];

  always_comb begin
    state_d   = state_q;
    hit_whole = 1'b0;
    hit_block = 1'b0;
    if (!accept) begin
      state_d = bypass ? D_BP : D_IDLE;
    end else if (take) begin
      unique case (state_q)
        D_IDLE:  state_d = (code == C_UNLK_A && at_a) ? D_UA1 : D_IDLE;
        D_UA1:   state_d = (code == C_UNLK_B && at_b) ? D_UB1 : D_IDLE;
        D_UB1: begin
          if (code == C_SETUP && at_a)       state_d = D_ARMED;
          else if (code == C_BYP_ON && at_a) state_d = D_BP;
          else                               state_d = D_IDLE;
        end
        D_ARMED: state_d = (code == C_UNLK_A && at_a) ? D_UA2 : D_IDLE;
        D_UA2:   state_d = (code == C_UNLK_B && at_b) ? D_UB2 : D_IDLE;
        D_UB2: begin
          state_d   = D_IDLE;
          hit_whole = (code == C_WHOLE) && at_a;
          hit_block = (code == C_BLOCK);
        end
        D_BP: begin
          if (code == C_SETUP)         state_d = D_BP_SET;
          else if (code == C_BYP_OFF1) state_d = D_BP_OFF;
          else                         state_d = D_BP;
        end
        D_BP_SET: begin
          state_d   = D_BP;
          hit_whole = (code == C_WHOLE);
        end
        D_BP_OFF: state_d = (code == C_BYP_OFF2) ? D_IDLE : D_BP;
        default:  state_d = D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= D_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/nor_erase_ctl.sv
module nor_erase_ctl
  import nor_erase_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hit_whole,
  input  logic          hit_block,
  input  logic          eng_done,
  input  logic          eng_err,
  output op_mode_e      mode,
  output logic          start,
  output logic          whole,
  output logic [AW-1:0] addr
);

  op_mode_e mode_q;
  logic start_q, whole_q;
  logic [AW-1:0] addr_q;
  logic reset_cmd;

  assign reset_cmd = wr_en && (wr_data[CODE_W-1:0] == C_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_READ;
      start_q <= 1'b0;
      whole_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (mode_q)
        MODE_READ: if (hit_whole || hit_block) begin
          mode_q  <= MODE_BUSY;
          start_q <= 1'b1;
          whole_q <= hit_whole;
          addr_q  <= wr_addr;
        end
        MODE_BUSY: if (eng_done) mode_q <= eng_err ? MODE_ERR : MODE_READ;
        MODE_ERR:  if (reset_cmd) mode_q <= MODE_READ;
        default:   mode_q <= MODE_READ;
      endcase
    end
  end

  assign mode  = mode_q;
  assign start = start_q;
  assign whole = whole_q;
  assign addr  = addr_q;

endmodule

// File: rtl/nor_read_port.sv
module nor_read_port
  import nor_erase_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  op_mode_e      mode,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] status;
  logic [DW-1:0] rdata_q;

  always_comb begin
    status = '0;
    status[STAT_BUSY] = (mode == MODE_BUSY);
    status[STAT_ERR]  = (mode == MODE_ERR);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= (mode == MODE_READ) ? arr_rdata : status;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd_en,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] bus_rdata,
  output logic          stat_mode,
  output logic          bypass_on,
  output logic          eng_start,
  output logic          eng_chip,
  output logic [AW-1:0] eng_addr,
  input  logic          eng_done,
  input  logic          eng_err
);

  op_mode_e mode_q;
  logic hit_whole, hit_block;

  nor_cmd_decoder #(.AW(AW), .DW(DW)) dec_i (
    .clk(clk), .rst(rst), .accept(mode_q == MODE_READ),
    .wr_en(bus_wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .hit_whole(hit_whole), .hit_block(hit_block), .bypass(bypass_on)
  );

  nor_erase_ctl #(.AW(AW), .DW(DW)) ctl_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .hit_whole(hit_whole), .hit_block(hit_block),
    .eng_done(eng_done), .eng_err(eng_err), .mode(mode_q),
    .start(eng_start), .whole(eng_chip), .addr(eng_addr)
  );

  nor_read_port #(.DW(DW)) rd_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .mode(mode_q),
    .arr_rdata(arr_rdata), .rdata(bus_rdata)
  );

  assign stat_mode = (mode_q != MODE_READ);

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    wr_code,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic          eng_start,
  input logic          eng_done,
  input logic          eng_err,
  input logic          stat_mode,
  input logic          bypass_on,
  input logic [1:0]    mode
);

  // R1, R2: a start always lands in status mode
  a_r1_start_enters_status: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> stat_mode);

  // R5: no start while an erase runs or after an error
  a_r5_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    stat_mode |=> !eng_start);

  // R4: a read while busy yields the busy status word
  a_r4_busy_status_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'd1) |=> (rdata == DW'(8'h80)));

  // R6: a clean finish returns to read mode
  a_r6_clean_done: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && eng_done && !eng_err) |=> !stat_mode);

  // R7: the error state stays until a reset code is written
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !(wr_en && wr_code == 8'hF0)) |=> (mode == 2'd2));

  // R3: bypass can only switch on because of a write
  a_r3_bypass_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_on) |-> $past(wr_en));

  // R9: hardware reset forces read mode with bypass off
  a_r9_hw_reset: assert property (@(posedge clk)
    rst |=> (!stat_mode && !bypass_on && !eng_start));

endmodule

bind nor_erase_seq nor_erase_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(bus_wr_en), .wr_code(bus_wdata[7:0]),
  .rd_en(bus_rd_en), .rdata(bus_rdata), .eng_start(eng_start),
  .eng_done(eng_done), .eng_err(eng_err), .stat_mode(stat_mode),
  .bypass_on(bypass_on), .mode(mode_q)
);

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd_en = 1'b0;
  logic [DW-1:0] arr_rdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          stat_mode, bypass_on, eng_start, eng_chip;
  logic [AW-1:0] eng_addr;
  logic          eng_done = 1'b0;
  logic          eng_err = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic last_start;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_erase_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .arr_rdata(arr_rdata),
    .bus_rdata(bus_rdata), .stat_mode(stat_mode), .bypass_on(bypass_on),
    .eng_start(eng_start), .eng_chip(eng_chip), .eng_addr(eng_addr),
    .eng_done(eng_done), .eng_err(eng_err)
  );

  function automatic logic [DW-1:0] status_word(input bit busy, input bit err);
    logic [DW-1:0] s;
    s = '0;
    s[7] = busy;
    s[5] = err;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    last_start = eng_start;
  endtask

  task automatic rd(input logic [DW-1:0] arr, output logic [DW-1:0] got);
    @(negedge clk);
    bus_rd_en = 1'b1; arr_rdata = arr;
    @(negedge clk);
    bus_rd_en = 1'b0;
    got = bus_rdata;
  endtask

  task automatic done(input bit err);
    @(negedge clk);
    eng_done = 1'b1; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic prefix5(output int starts);
    starts = 0;
    wr(16'h0555, 8'hAA); starts += int'(last_start);
    wr(16'h02AA, 8'h55); starts += int'(last_start);
    wr(16'h0555, 8'h80); starts += int'(last_start);
    wr(16'h0555, 8'hAA); starts += int'(last_start);
    wr(16'h02AA, 8'h55); starts += int'(last_start);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] got;
    int early;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!stat_mode && !bypass_on && !eng_start, "R9 reset state",
          {stat_mode, bypass_on, eng_start}, 0);

    // R1: whole-array erase
    prefix5(early);
    check(early == 0, "R1 no early start", early, 0);
    wr(16'h0555, 8'h10);
    check(last_start && eng_chip, "R1 whole start", {last_start, eng_chip}, 3);
    @(negedge clk);
    check(!eng_start, "R1 start is one cycle", eng_start, 0);
    // R4: status read while busy
    rd(8'h3C, got);
    check(got == status_word(1, 0), "R4 busy status", got, status_word(1, 0));
    // R5: writes ignored while busy
    wr(16'h0000, 8'hF0);
    prefix5(early);
    wr(16'h0555, 8'h10);
    check(early == 0 && !last_start && stat_mode, "R5 writes ignored", {early[3:0], last_start, stat_mode}, 1);
    rd(8'h3C, got);
    check(got == status_word(1, 0), "R5 status kept", got, status_word(1, 0));
    // R6: clean finish
    done(1'b0);
    check(!stat_mode, "R6 back to read", stat_mode, 0);
    rd(8'h5A, got);
    check(got == 8'h5A, "R6 array read", got, 8'h5A);

    // R7: error path
    prefix5(early);
    wr(16'hBEEF, 8'h30);
    done(1'b1);
    rd(8'h11, got);
    check(got == status_word(0, 1), "R7 error status", got, status_word(0, 1));
    prefix5(early);
    wr(16'h0555, 8'h10);
    check(!last_start && stat_mode, "R7 sticky through writes", {last_start, stat_mode}, 1);
    wr(16'h1234, 8'hF0);
    check(!stat_mode, "R7 reset code clears", stat_mode, 0);
    rd(8'h77, got);
    check(got == 8'h77, "R7 array after clear", got, 8'h77);

    // R8: broken sequences
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h12);
    wr(16'h0555, 8'h10);
    check(!last_start && !stat_mode, "R8 wrong code", {last_start, stat_mode}, 0);
    wr(16'h0555, 8'hAA); wr(16'h0556, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'h10);
    check(!last_start && !stat_mode, "R8 wrong address", {last_start, stat_mode}, 0);
    prefix5(early);
    wr(16'h0555, 8'h10);
    check(last_start && early == 0, "R8 recovers after break", last_start, 1);
    done(1'b0);

    // R3: bypass
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h20);
    check(bypass_on, "R3 bypass on", bypass_on, 1);
    wr(16'h4000, 8'h80);
    wr(16'h7777, 8'h10);
    check(last_start && eng_chip, "R3 two-write erase", {last_start, eng_chip}, 3);
    done(1'b0);
    check(bypass_on && !stat_mode, "R3 bypass kept after erase", {bypass_on, stat_mode}, 2);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
    check(!bypass_on, "R3 bypass off", bypass_on, 1'b0);
    wr(16'h4000, 8'h80); wr(16'h7777, 8'h10);
    check(!last_start, "R3 two writes ignored outside bypass", last_start, 0);

    // R9: hardware reset aborts
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h20);
    wr(16'h0001, 8'h80); wr(16'h0001, 8'h10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!stat_mode && !bypass_on, "R9 abort", {stat_mode, bypass_on}, 0);

    // R2, R10: random block erases and array reads
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] ba;
      logic [DW-1:0] ad;
      ad = DW'($urandom);
      rd(ad, got);
      check(got == ad, "R10 array read", got, ad);
      ba = AW'($urandom);
      // random non-command noise first
      wr(AW'($urandom), 8'h01 + DW'($urandom_range(0, 14)));
      prefix5(early);
      wr(ba, 8'h30);
      check(last_start && !eng_chip && eng_addr == ba && early == 0, "R2 block start",
            {last_start, eng_chip, eng_addr}, {1'b1, 1'b0, ba});
      rd(ad, got);
      check(got == status_word(1, 0), "R4 status in block erase", got, status_word(1, 0));
      done(1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule